// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher

This block decides, on each one-second update of a time-of-day clock, whether the programmed alarm time has been reached. It takes three alarm bytes (second, minute, hour) and the three current time bytes. It also takes a mode bit that selects BCD or plain binary encoding and a bit that selects 24-hour or 12-hour hour format. A one-cycle update strobe marks each second. The time counters that feed the block and any interrupt masking that uses its flag live outside it.

Each byte is decoded to a plain number before the compare. Any alarm byte whose two most significant bits are both set is a don't-care and matches every time value. On each strobe the block registers two single-cycle flags. One marks the second update itself. The other marks an alarm match. Both can rise in the same cycle.

The time bytes presented together with the strobe must already hold the newly advanced time. An alarm that equals that time therefore fires at that update, and never between strobes.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, and until the first update strobe, both `alarm_flag_o` and `update_flag_o` are 0.
- R2: `update_flag_o` is 1 in exactly the cycle after each cycle in which `tick_i` is 1, and 0 otherwise. Back-to-back strobes give back-to-back flags.
- R3: `alarm_flag_o` is 1 in the cycle after a strobe if and only if every alarm field matches the corresponding time field at that strobe. It is never 1 after a cycle without a strobe.
- R4: An alarm byte with bits 7 and 6 both 1 (byte & 0xC0 == 0xC0) matches any time value of its field, whatever the other fields do.
- R5: With all three alarm bytes set to the don't-care pattern, every strobe produces an alarm flag.
- R6: With `bin_mode_i` = 0 (BCD), a byte decodes as upper nibble × 10 + lower nibble. A byte with either nibble above 9 is out of range.
- R7: With `bin_mode_i` = 1 (binary), a byte is taken as its unsigned value. For example, 0x3B is 59.
- R8: With `hr24_i` = 0 (12-hour), the hour byte's bits 6:0 decode to a value in 1..12. That value is taken modulo 12, and 12 is added when bit 7 (PM) is 1. So 0x12 (BCD) is hour 0, 0x92 is hour 12 and 0x87 is hour 19. With `hr24_i` = 1, the whole byte is the hour.
- R9: A non-don't-care field whose decoded value is out of range never matches, even against an identical time byte. The ranges are seconds 0..59, minutes 0..59, 24-hour hours 0..23, and 12-hour hours 1..12 before the PM adjustment.
- R10: The compare uses the time bytes present in the strobe cycle. A matching time presented without a strobe raises no flag. The same values with a strobe fire at that update.
- R11: Whenever `alarm_flag_o` is 1, `update_flag_o` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second update strobe, one cycle wide, time bytes already advanced |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_i | input | 1 | 1 = 24-hour hour byte, 0 = 12-hour with PM in bit 7 |
| alm_sec_i | input | 8 | Alarm second byte |
| alm_min_i | input | 8 | Alarm minute byte |
| alm_hr_i | input | 8 | Alarm hour byte |
| tod_sec_i | input | 8 | Current second byte |
| tod_min_i | input | 8 | Current minute byte |
| tod_hr_i | input | 8 | Current hour byte |
| alarm_flag_o | output | 1 | One-cycle alarm match flag |
| update_flag_o | output | 1 | One-cycle second-update flag |

## Verification
The alarm flag and the update flag come from the same strobe, so they can rise together. Every matching scenario drives one strobe with an alarm equal to the presented time, in both encodings and both hour formats. One cycle later the check requires both flags at 1, and in the following cycle both at 0. Non-matching strobes must show the update flag alone. Matching values held without a strobe must show neither flag. Back-to-back strobes with all fields don't-care must keep both flags high for two consecutive cycles.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 3;
    localparam int SEC_LIMIT  = 60;
    localparam int MIN_LIMIT  = 60;
    localparam int HR_LIMIT   = 24;

    typedef logic [BYTE_W-1:0] tbyte_t;

    typedef struct packed {
        logic alarm;
        logic upd;
    } flag_state_t;

    // limit per field index: 0 = seconds, 1 = minutes, 2 = hours
    function automatic int field_limit(input int idx);
        case (idx)
            0:       return SEC_LIMIT;
            1:       return MIN_LIMIT;
            default: return HR_LIMIT;
        endcase
    endfunction

endpackage

// File: rtl/alm_field_dec.sv
module alm_field_dec
    import alm_pkg::*;
#(
    parameter int LIMIT = 60
) (
    input  tbyte_t raw_i,
    input  logic   bin_mode_i,
    input  logic   h12_i,
    output logic   wild_o,
    output logic   valid_o,
    output tbyte_t value_o
);

    localparam tbyte_t LIM8   = tbyte_t'(LIMIT);
    localparam tbyte_t TWELVE = tbyte_t'(12);
    localparam tbyte_t TEN    = tbyte_t'(10);

    tbyte_t body;
    tbyte_t conv;
    logic   pm;
    logic   digits_ok;
    logic   range_ok;

    always_comb begin
        wild_o = (raw_i[7:6] == 2'b11);
        pm     = h12_i & raw_i[7];
        body   = h12_i ? {1'b0, raw_i[6:0]} : raw_i;

        if (bin_mode_i) begin
            conv      = body;
            digits_ok = 1'b1;
        end else begin
            conv      = {4'b0, body[7:4]} * TEN + {4'b0, body[3:0]};
            digits_ok = (body[3:0] <= 4'd9) && (body[7:4] <= 4'd9);
        end

        if (h12_i) begin
            range_ok = (conv >= 8'd1) && (conv <= TWELVE);
            value_o  = ((conv == TWELVE) ? 8'd0 : conv) + (pm ? TWELVE : 8'd0);
        end else begin
            range_ok = (conv < LIM8);
            value_o  = conv;
        end

        valid_o = !wild_o && digits_ok && range_ok;
    end

    // R9
    always_comb begin
        value_range_chk: assert (!valid_o || (value_o < LIM8));
    end

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import alm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   bin_mode_i,
    input  logic   hr24_i,
    input  tbyte_t alm_sec_i,
    input  tbyte_t alm_min_i,
    input  tbyte_t alm_hr_i,
    input  tbyte_t tod_sec_i,
    input  tbyte_t tod_min_i,
    input  tbyte_t tod_hr_i,
    output logic   alarm_flag_o,
    output logic   update_flag_o
);

    localparam int HR_IDX = NUM_FIELDS - 1;

    tbyte_t [NUM_FIELDS-1:0] alm_bytes;
    tbyte_t [NUM_FIELDS-1:0] tod_bytes;
    tbyte_t [NUM_FIELDS-1:0] alm_val;
    tbyte_t [NUM_FIELDS-1:0] tod_val;
    logic   [NUM_FIELDS-1:0] alm_wild;
    logic   [NUM_FIELDS-1:0] alm_valid;
    logic   [NUM_FIELDS-1:0] tod_wild;
    logic   [NUM_FIELDS-1:0] tod_valid;
    logic   [NUM_FIELDS-1:0] field_hit;
    logic                    all_hit;

    flag_state_t st_d, st_q;

    assign alm_bytes = {alm_hr_i, alm_min_i, alm_sec_i};
    assign tod_bytes = {tod_hr_i, tod_min_i, tod_sec_i};

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        logic h12;
        assign h12 = (i == HR_IDX) ? ~hr24_i : 1'b0;

        alm_field_dec #(.LIMIT(field_limit(i))) u_alm_dec (
            .raw_i      (alm_bytes[i]),
            .bin_mode_i (bin_mode_i),
            .h12_i      (h12),
            .wild_o     (alm_wild[i]),
            .valid_o    (alm_valid[i]),
            .value_o    (alm_val[i])
        );

        alm_field_dec #(.LIMIT(field_limit(i))) u_tod_dec (
            .raw_i      (tod_bytes[i]),
            .bin_mode_i (bin_mode_i),
            .h12_i      (h12),
            .wild_o     (tod_wild[i]),
            .valid_o    (tod_valid[i]),
            .value_o    (tod_val[i])
        );

        assign field_hit[i] = alm_wild[i]
                            | (alm_valid[i] & tod_valid[i] & ~tod_wild[i]
                               & (alm_val[i] == tod_val[i]));
    end

    assign all_hit = &field_hit;

    always_comb begin
        st_d       = st_q;
        st_d.upd   = tick_i;
        st_d.alarm = tick_i & all_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_flag_o  = st_q.alarm;
    assign update_flag_o = st_q.upd;

    // R11
    alarm_with_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_flag_o |-> update_flag_o);

    // R2
    update_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> update_flag_o);

    // R2
    no_update_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !update_flag_o);

    // R5
    all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (&alm_wild)) |=> alarm_flag_o);

    // R9
    bad_field_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (|(~alm_wild & ~alm_valid))) |=> !alarm_flag_o);

endmodule

// File: tb/tb_tod_alarm_match.sv
module tb_tod_alarm_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       bin_mode_i = 1'b0;
    logic       hr24_i = 1'b1;
    logic [7:0] alm_sec_i = '0, alm_min_i = '0, alm_hr_i = '0;
    logic [7:0] tod_sec_i = '0, tod_min_i = '0, tod_hr_i = '0;
    logic       alarm_flag_o, update_flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tod_alarm_match dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
        .alm_sec_i(alm_sec_i), .alm_min_i(alm_min_i), .alm_hr_i(alm_hr_i),
        .tod_sec_i(tod_sec_i), .tod_min_i(tod_min_i), .tod_hr_i(tod_hr_i),
        .alarm_flag_o(alarm_flag_o), .update_flag_o(update_flag_o)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic setup(input logic bin, input logic h24,
                         input logic [7:0] a_s, input logic [7:0] a_m, input logic [7:0] a_h,
                         input logic [7:0] t_s, input logic [7:0] t_m, input logic [7:0] t_h);
        @(negedge clk);
        bin_mode_i = bin; hr24_i = h24;
        alm_sec_i = a_s; alm_min_i = a_m; alm_hr_i = a_h;
        tod_sec_i = t_s; tod_min_i = t_m; tod_hr_i = t_h;
    endtask

    // one strobe; flags are registered at the edge inside the strobe cycle
    task automatic strobe_and_check(input string req, input logic exp_alarm);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check(req, alarm_flag_o, exp_alarm, "alarm flag after strobe");
        check("R11", update_flag_o, 1'b1, "update flag with strobe");
        @(negedge clk);
        check("R2", update_flag_o, 1'b0, "update flag drops");
        check("R3", alarm_flag_o, 1'b0, "alarm flag drops");
    endtask

    task automatic t_reset;
        check("R1", alarm_flag_o, 1'b0, "alarm after reset");
        check("R1", update_flag_o, 1'b0, "update after reset");
    endtask

    task automatic t_bcd;
        setup(1'b0, 1'b1, 8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12);
        strobe_and_check("R6", 1'b1);
        setup(1'b0, 1'b1, 8'h56, 8'h34, 8'h12, 8'h57, 8'h34, 8'h12);
        strobe_and_check("R3", 1'b0);
        setup(1'b0, 1'b1, 8'h00, 8'h00, 8'h23, 8'h00, 8'h00, 8'h23);
        strobe_and_check("R6", 1'b1);
    endtask

    task automatic t_binary;
        setup(1'b1, 1'b1, 8'h3B, 8'h22, 8'h17, 8'h3B, 8'h22, 8'h17);
        strobe_and_check("R7", 1'b1);
        setup(1'b1, 1'b1, 8'h3B, 8'h22, 8'h17, 8'h3B, 8'h21, 8'h17);
        strobe_and_check("R7", 1'b0);
    endtask

    task automatic t_wild;
        setup(1'b0, 1'b1, 8'hC5, 8'h34, 8'h12, 8'h07, 8'h34, 8'h12);
        strobe_and_check("R4", 1'b1);
        setup(1'b0, 1'b1, 8'h07, 8'hFF, 8'h12, 8'h07, 8'h59, 8'h12);
        strobe_and_check("R4", 1'b1);
        setup(1'b0, 1'b1, 8'h07, 8'hFF, 8'hD0, 8'h08, 8'h59, 8'h12);
        strobe_and_check("R4", 1'b0);
    endtask

    task automatic t_all_wild;
        for (int k = 0; k < 3; k++) begin
            setup(1'(k % 2), 1'b1, 8'hC0, 8'hC0, 8'hC0, 8'(k * 7), 8'(k * 5), 8'(k));
            strobe_and_check("R5", 1'b1);
        end
    endtask

    task automatic t_twelve;
        setup(1'b0, 1'b0, 8'h00, 8'h15, 8'h87, 8'h00, 8'h15, 8'h87);
        strobe_and_check("R8", 1'b1);
        setup(1'b0, 1'b0, 8'h00, 8'h15, 8'h07, 8'h00, 8'h15, 8'h87);
        strobe_and_check("R8", 1'b0);
        setup(1'b0, 1'b0, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h92);
        strobe_and_check("R8", 1'b0);
        setup(1'b0, 1'b0, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h92);
        strobe_and_check("R8", 1'b1);
        setup(1'b1, 1'b0, 8'h00, 8'h00, 8'h8C, 8'h00, 8'h00, 8'h8C);
        strobe_and_check("R8", 1'b1);
    endtask

    task automatic t_range;
        setup(1'b0, 1'b1, 8'h60, 8'h00, 8'h00, 8'h60, 8'h00, 8'h00);
        strobe_and_check("R9", 1'b0);
        setup(1'b0, 1'b1, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'h00, 8'h00);
        strobe_and_check("R9", 1'b0);
        setup(1'b1, 1'b1, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h3C, 8'h00);
        strobe_and_check("R9", 1'b0);
        setup(1'b0, 1'b1, 8'h00, 8'h00, 8'h24, 8'h00, 8'h00, 8'h24);
        strobe_and_check("R9", 1'b0);
        setup(1'b0, 1'b0, 8'h00, 8'h00, 8'h13, 8'h00, 8'h00, 8'h13);
        strobe_and_check("R9", 1'b0);
    endtask

    task automatic t_no_strobe;
        setup(1'b0, 1'b1, 8'h05, 8'h00, 8'h10, 8'h05, 8'h00, 8'h10);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10", alarm_flag_o, 1'b0, "no alarm without strobe");
            check("R10", update_flag_o, 1'b0, "no update without strobe");
        end
        strobe_and_check("R10", 1'b1);
    endtask

    task automatic t_back_to_back;
        setup(1'b0, 1'b1, 8'hC0, 8'hC0, 8'hC0, 8'h01, 8'h02, 8'h03);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        check("R2", update_flag_o, 1'b1, "first of two updates");
        check("R11", alarm_flag_o, 1'b1, "first of two alarms");
        @(negedge clk);
        tick_i = 1'b0;
        check("R2", update_flag_o, 1'b1, "second of two updates");
        check("R11", alarm_flag_o, 1'b1, "second of two alarms");
        @(negedge clk);
        check("R2", update_flag_o, 1'b0, "update idle after pair");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bcd();
        t_binary();
        t_wild();
        t_all_wild();
        t_twelve();
        t_range();
        t_no_strobe();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule